// File: doc/BRIEF.md
# Four-Lane Seven-to-One Serial Link Transmitter

This block turns a 28-bit parallel word into four serial data lanes and one forwarded-clock lane. It runs entirely on a bit clock that is seven times faster than the pixel clock, which the block receives as a sampled signal. A selectable edge of the pixel clock captures the parallel word into a holding register. A free-running frame counter, 0 to 6, moves the held word into the lane shift registers on count 0. Each lane then sends its 7-bit slice, lowest bit first, over the next seven bit-clock cycles. The fifth lane sends a fixed 7-bit pattern on every frame, so the receiver sees one clock period per word.

The link runs at a fixed rate and applies no back-pressure. A word is taken on each selected pixel-clock edge, and the most recent capture is the one sent in the next frame. The active-low shutdown input clears every register, forces all lanes and the driver enable low in the same cycle, and restarts the frame counter from 0 when it is released.

Top module: `slice7_link_tx`

## Requirements
- R1: Lane k (k = 0..3) carries word bits 7k..7k+6, and bit 7k goes out first in the frame.
- R2: A frame lasts 7 bit-clock cycles. The frame counter runs 0..6 and wraps, and restarts at 0 on the first edge after shutdown is released, where it loads the lanes. Output bit i of a frame is valid after load edge + i.
- R3: Once a captured word has been loaded, the forwarded-clock lane sends the bits 1,1,0,0,0,1,1 in every frame, in that order.
- R4: With `rise_sel` = 1 the word is captured on a rising edge of `pix_clk`. With `rise_sel` = 0 it is captured on a falling edge. The opposite edge captures nothing.
- R5: While `shdn_n` is 0, `lane_o`, `clk_lane_o` and `drv_en_o` are 0 in the same cycle.
- R6: Shutdown empties the holding register. After release, all five lanes send 0 until a word captured after the release has been loaded.
- R7: If no capture edge occurs during a frame, the next frame sends the previously held word again.
- R8: `drv_en_o` is 1 from the first bit-clock edge after release for as long as `shdn_n` stays 1.
- R9: A word captured during one frame is sent in the frame that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the pixel rate |
| shdn_n | input | 1 | Active-low shutdown and clear |
| pix_clk | input | 1 | Pixel clock, sampled on clk |
| rise_sel | input | 1 | 1: capture on rising pixel edge, 0: on falling |
| word_i | input | 28 | Parallel word |
| lane_o | output | 4 | Serial data lanes |
| clk_lane_o | output | 1 | Forwarded-clock serial lane |
| drv_en_o | output | 1 | Lane driver enable |

## Verification
The bench builds the block with its default values: seven bits per slice, four lanes and the 1100011 clock pattern. These defaults keep every frame position and every lane within a single 28-bit word, so single-bit words can be placed at the first and last slot of each lane. The bench changes the word halfway through a pixel period, so the two capture-edge settings must pick different words. It also drops shutdown in the middle of a frame to show the clear, the idle outputs and the realigned frame after release.

// File: rtl/s7_pkg.sv
package s7_pkg;
  localparam int unsigned S7_SLICE = 7;
  localparam int unsigned S7_LANES = 4;
  // forwarded clock bits, bit 0 sent first
  localparam logic [S7_SLICE-1:0] S7_FWD_PAT = 7'b1100011;
endpackage

// File: rtl/s7_frame_timer.sv
module s7_frame_timer #(
  parameter int unsigned SLICE = s7_pkg::S7_SLICE
) (
  input  logic                     clk,
  input  logic                     clr,
  output logic [$clog2(SLICE)-1:0] cnt_o,
  output logic                     load_o
);
  localparam int unsigned CW = $clog2(SLICE);
  localparam logic [CW-1:0] LAST = CW'(SLICE - 1);

  always_ff @(posedge clk) begin
    if (clr)                cnt_o <= '0;
    else if (cnt_o == LAST) cnt_o <= '0;
    else                    cnt_o <= cnt_o + 1'b1;
  end

  assign load_o = (cnt_o == '0);

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (clr)
    cnt_o <= LAST);
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (clr)
    (cnt_o != LAST) |=> (cnt_o == $past(cnt_o) + 1'b1));
  p_cnt_wrap_r2: assert property (@(posedge clk) disable iff (clr)
    (cnt_o == LAST) |=> (cnt_o == '0));
endmodule

// File: rtl/s7_edge_capture.sv
module s7_edge_capture #(
  parameter int unsigned W = 28
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         pix_i,
  input  logic         rise_sel_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] held_o,
  output logic         vld_o
);
  logic pix_q;
  logic rise, fall, take;

  assign rise = pix_i & ~pix_q;
  assign fall = ~pix_i & pix_q;
  assign take = rise_sel_i ? rise : fall;

  always_ff @(posedge clk) begin
    if (clr) begin
      pix_q  <= 1'b0;
      held_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      pix_q <= pix_i;
      if (take) begin
        held_o <= din_i;
        vld_o  <= 1'b1;
      end
    end
  end

  p_rise_capture_r4: assert property (@(posedge clk) disable iff (clr)
    (rise_sel_i && pix_i && !pix_q) |=> (held_o == $past(din_i)));
  p_fall_capture_r4: assert property (@(posedge clk) disable iff (clr)
    (!rise_sel_i && !pix_i && pix_q) |=> (held_o == $past(din_i)));
  p_hold_r7: assert property (@(posedge clk) disable iff (clr)
    (pix_i == pix_q) |=> $stable(held_o));
endmodule

// File: rtl/s7_lane_shift.sv
module s7_lane_shift #(
  parameter int unsigned W = s7_pkg::S7_SLICE
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  output logic         sout_o
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (clr)         sr <= '0;
    else if (load_i) sr <= din_i;
    else             sr <= {1'b0, sr[W-1:1]};
  end

  assign sout_o = sr[0];
endmodule

// File: rtl/slice7_link_tx.sv
module slice7_link_tx #(
  parameter int unsigned SLICE = s7_pkg::S7_SLICE,
  parameter int unsigned LANES = s7_pkg::S7_LANES,
  parameter logic [SLICE-1:0] FWD_PAT = s7_pkg::S7_FWD_PAT
) (
  input  logic                   clk,
  input  logic                   shdn_n,
  input  logic                   pix_clk,
  input  logic                   rise_sel,
  input  logic [LANES*SLICE-1:0] word_i,
  output logic [LANES-1:0]       lane_o,
  output logic                   clk_lane_o,
  output logic                   drv_en_o
);
  localparam int unsigned WORD_W = LANES * SLICE;
  localparam int unsigned CW     = $clog2(SLICE);

  logic              clr;
  logic [CW-1:0]     fcnt;
  logic              load;
  logic [WORD_W-1:0] held;
  logic              held_vld;
  logic [LANES-1:0]  lane_raw;
  logic              clk_raw;
  logic              live_q;
  logic              en_q;

  assign clr = ~shdn_n;

  s7_frame_timer #(.SLICE(SLICE)) u_timer (
    .clk(clk), .clr(clr), .cnt_o(fcnt), .load_o(load)
  );

  s7_edge_capture #(.W(WORD_W)) u_cap (
    .clk(clk), .clr(clr), .pix_i(pix_clk), .rise_sel_i(rise_sel),
    .din_i(word_i), .held_o(held), .vld_o(held_vld)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    s7_lane_shift #(.W(SLICE)) u_lane (
      .clk(clk), .clr(clr), .load_i(load),
      .din_i(held[k*SLICE +: SLICE]), .sout_o(lane_raw[k])
    );
  end

  s7_lane_shift #(.W(SLICE)) u_fwd (
    .clk(clk), .clr(clr), .load_i(load),
    .din_i(held_vld ? FWD_PAT : '0), .sout_o(clk_raw)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      live_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      en_q <= 1'b1;
      if (load && held_vld) live_q <= 1'b1;
    end
  end

  assign lane_o     = lane_raw & {LANES{shdn_n}};
  assign clk_lane_o = clk_raw & shdn_n;
  assign drv_en_o   = en_q & shdn_n;

  // position of the bit currently on the lanes, for the clock-lane check
  logic [CW-1:0] pat_idx;
  always_comb pat_idx = (fcnt == '0) ? CW'(SLICE - 1) : fcnt - 1'b1;

  p_fwd_pattern_r3: assert property (@(posedge clk) disable iff (clr)
    live_q |-> (clk_lane_o == FWD_PAT[pat_idx]));
  p_idle_after_release_r6: assert property (@(posedge clk)
    $rose(shdn_n) |-> (lane_o == '0 && clk_lane_o == 1'b0));
  p_enable_r8: assert property (@(posedge clk) disable iff (clr)
    shdn_n |=> drv_en_o);
  p_silent_unloaded_r6: assert property (@(posedge clk) disable iff (clr)
    !live_q |-> (clk_lane_o == 1'b0));
endmodule

// File: tb/sim_slice7_link_tx.sv
module sim_slice7_link_tx;
  logic        clk = 1'b0;
  logic        shdn_n = 1'b0;
  logic        pix = 1'b0;
  logic        rise_sel = 1'b1;
  logic [27:0] word = '0;
  logic [3:0]  lane_o;
  logic        clk_lane_o;
  logic        drv_en_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [6:0] PAT = 7'b1100011;

  typedef struct packed {
    logic        sel;
    logic [27:0] a;
    logic [27:0] b;
    logic [27:0] exp;
  } vec_t;

  // a: word during first half of the pixel period, b: second half
  localparam vec_t VECS [8] = '{
    '{1'b1, 28'h0000001, 28'hFFFFFFF, 28'h0000001},
    '{1'b0, 28'h0000001, 28'h8000000, 28'h8000000},
    '{1'b1, 28'hAAAAAAA, 28'h5555555, 28'hAAAAAAA},
    '{1'b0, 28'h1234567, 28'h7654321, 28'h7654321},
    '{1'b1, 28'hFFFFFFF, 28'h0000000, 28'hFFFFFFF},
    '{1'b0, 28'h0000000, 28'h0204081, 28'h0204081},
    '{1'b1, 28'hFE00000, 28'h0000001, 28'hFE00000},
    '{1'b0, 28'h0000001, 28'h0000040, 28'h0000040}
  };

  always #4 clk = ~clk;

  slice7_link_tx u0 (
    .clk(clk), .shdn_n(shdn_n), .pix_clk(pix), .rise_sel(rise_sel),
    .word_i(word), .lane_o(lane_o), .clk_lane_o(clk_lane_o),
    .drv_en_o(drv_en_o)
  );

  task automatic check(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // entered at the negedge just after a load edge; leaves at the next one
  task automatic do_frame(input logic sel, input logic [27:0] a,
                          input logic [27:0] b, input bit pulse,
                          input logic [27:0] exp_w, input logic [6:0] exp_c,
                          input string tag);
    logic [27:0] got_w = '0;
    logic [6:0]  got_c = '0;
    bit          en_ok = 1'b1;
    for (int i = 0; i < 7; i++) begin
      for (int k = 0; k < 4; k++) got_w[7*k+i] = lane_o[k];
      got_c[i] = clk_lane_o;
      if (!drv_en_o) en_ok = 1'b0;
      rise_sel = sel;
      word = (i < 4) ? a : b;
      if (pulse) pix = (i < 4);
      @(negedge clk);
    end
    check(got_w == exp_w, {tag, " R1 R9 lane word"}, {4'h0, got_w}, {4'h0, exp_w});
    check(got_c == exp_c, {tag, " R3 clock lane"}, {25'h0, got_c}, {25'h0, exp_c});
    check(en_ok, {tag, " R8 driver enable"}, {31'h0, en_ok}, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R5: held in shutdown since time zero
    check(lane_o == 4'h0 && !clk_lane_o && !drv_en_o, "R5 idle in shutdown",
          {26'h0, lane_o, clk_lane_o, drv_en_o}, 32'h0);

    shdn_n = 1'b1;
    @(negedge clk);
    // first frame after release: nothing captured yet (R6)
    do_frame(VECS[0].sel, VECS[0].a, VECS[0].b, 1'b1, 28'h0, 7'h0, "R6 first frame");
    for (int v = 1; v < 8; v++)
      do_frame(VECS[v].sel, VECS[v].a, VECS[v].b, 1'b1, VECS[v-1].exp, PAT, "R4 vector");
    // no capture edges: held word repeats (R7)
    do_frame(1'b1, 28'h1111111, 28'h2222222, 1'b0, VECS[7].exp, PAT, "R4 last vector");
    do_frame(1'b0, 28'h3333333, 28'h4444444, 1'b0, VECS[7].exp, PAT, "R7 repeat");
    do_frame(1'b1, 28'h0C3A5F1, 28'h0C3A5F1, 1'b1, VECS[7].exp, PAT, "R7 repeat again");

    // shutdown in the middle of a frame
    repeat (3) @(negedge clk);
    shdn_n = 1'b0;
    #1;
    check(lane_o == 4'h0 && !clk_lane_o && !drv_en_o, "R5 same-cycle idle",
          {26'h0, lane_o, clk_lane_o, drv_en_o}, 32'h0);
    repeat (3) @(negedge clk);
    check(lane_o == 4'h0 && !clk_lane_o && !drv_en_o, "R5 idle held",
          {26'h0, lane_o, clk_lane_o, drv_en_o}, 32'h0);

    shdn_n = 1'b1;
    @(negedge clk);
    // captured word before shutdown must be gone (R6); frame realigned (R2)
    do_frame(1'b1, 28'h5A5A5A5, 28'h0F0F0F0, 1'b1, 28'h0, 7'h0, "R6 cleared");
    do_frame(1'b0, 28'h1111111, 28'h0F0F0F0, 1'b1, 28'h5A5A5A5, PAT, "R2 realigned");
    do_frame(1'b0, 28'h0, 28'h0, 1'b0, 28'h0F0F0F0, PAT, "R4 falling after restart");

    done = 1'b1;
    finish_run();
  end
endmodule